// File: doc/BRIEF.md
# Fast Link Pulse Burst Generator

This block turns a 16-bit link code word into the pulse train that two link partners use to advertise their abilities during auto-negotiation. A burst is a row of bit slots. Each slot opens with a clock pulse. When the code bit for that slot is one, a data pulse follows partway through the slot. One more clock pulse closes the burst. While negotiation is enabled, the block sends a fresh burst at a fixed repetition period.

The code word is captured when a burst begins, so the negotiation logic may update it at any time. Dropping the enable lets the burst in flight run to its end and then stops the train. Pulse width, slot spacing, data-pulse offset and repetition period are given in nanoseconds. They are converted to clock cycles from a clock-frequency parameter when the design is elaborated. At the default values the block produces pulses 100 ns wide, clock pulses 125 µs apart, data pulses 62 µs after their clock pulse, and a new burst every 16 ms.

Top module: `flp_burst_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `link_pulse`, `burst_active` and `burst_done` are all 0.
- R2: A burst has NBITS+1 slots, numbered 0 to NBITS, each SLOT cycles long. `link_pulse` is high for the first PW cycles of every slot.
- R3: In slot k (k < NBITS), a code bit of 1 raises `link_pulse` for PW cycles starting DOFS cycles into the slot. A code bit of 0 leaves the data part of the slot low. The last slot (k = NBITS) never carries a data pulse.
- R4: The code word is sent least significant bit first: bit k is carried in slot k.
- R5: `code_word` is captured on the clock edge that starts a burst. A change to `code_word` during a burst does not alter that burst.
- R6: While `enable` stays high, consecutive bursts start exactly PERIOD cycles apart.
- R7: If `enable` falls during a burst, that burst completes unchanged and no further burst starts. With `enable` low and no burst in flight, all outputs stay low.
- R8: `burst_active` is high from the first cycle of the first clock pulse to the last cycle of the final clock pulse, which is NBITS*SLOT+PW cycles. `burst_done` is high for exactly one cycle, the cycle right after `burst_active` falls.
- R9: Each cycle count (PW, SLOT, DOFS, PERIOD) equals its nanosecond parameter times CLK_HZ divided by 10^9, rounded up. For example, 20 ns at 125 MHz gives 3 cycles.
- R10: When idle, `enable` sampled high at a clock edge starts a burst at that edge. `burst_active` and `link_pulse` are high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High while negotiation wants bursts to be sent |
| code_word | input | NBITS | Link code word, captured at each burst start |
| link_pulse | output | 1 | Serial clock/data pulse line |
| burst_active | output | 1 | High for the duration of a burst |
| burst_done | output | 1 | One-cycle strobe after each burst ends |

## Verification
The bench sweeps walking-one words and dense and alternating patterns. Each burst is compared cycle by cycle against a model computed from slot arithmetic, which exposes a swapped bit order, a data pulse in the closing slot, or a data pulse offset by one cycle. The code word is changed partway through every burst; a design that reads the live input instead of its captured copy shows the new bits in the second half of the burst. The sub-cycle pulse width catches a conversion that truncates instead of rounding up, because every pulse would then be one cycle short. Enable is dropped mid-burst, then raised again after an idle stretch. A design that cuts the burst short, emits one extra burst, or is late to restart from idle is reported.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef int unsigned cyc_t;

    // Burst sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BURST = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;

    // Control handed from the sequencer to the slot counter and encoder
    typedef struct packed {
        logic launch;    // a burst starts at this clock edge
        logic in_burst;  // the current cycle belongs to a burst
    } seq_ctl_t;

    // Nanoseconds to clock cycles, rounded up
    function automatic cyc_t ns_to_cyc(input longint unsigned hz, input longint unsigned ns);
        longint unsigned prod;
        prod = hz * ns;
        return cyc_t'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    // Bits needed to hold values 0 .. n-1
    function automatic cyc_t cnt_width(input cyc_t n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/flp_sequencer.sv
module flp_sequencer import flp_pkg::*; #(
    parameter cyc_t PERIOD_CYC = 2_000_000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     burst_last,
    output seq_ctl_t ctl,
    output logic     done_o
);
    localparam cyc_t PER_W = cnt_width(PERIOD_CYC);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_CYC - 1);

    seq_state_e       st_q, st_d;
    logic [PER_W-1:0] per_q, per_d;
    logic             launch;
    logic             done_q;

    always_comb begin
        launch = 1'b0;
        st_d   = st_q;
        per_d  = per_q + 1'b1;
        unique case (st_q)
            SEQ_IDLE: begin
                per_d = '0;
                if (enable) begin
                    launch = 1'b1;
                    st_d   = SEQ_BURST;
                end
            end
            SEQ_BURST: begin
                if (burst_last) st_d = SEQ_GAP;
            end
            SEQ_GAP: begin
                if (per_q == PER_LAST) begin
                    per_d = '0;
                    if (enable) begin
                        launch = 1'b1;
                        st_d   = SEQ_BURST;
                    end else begin
                        st_d = SEQ_IDLE;
                    end
                end
            end
            default: begin
                st_d  = SEQ_IDLE;
                per_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            per_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            per_q  <= per_d;
            done_q <= (st_q == SEQ_BURST) && burst_last;
        end
    end

    assign ctl.launch   = launch;
    assign ctl.in_burst = (st_q == SEQ_BURST);
    assign done_o       = done_q;

endmodule

// File: rtl/flp_slot_counter.sv
module flp_slot_counter import flp_pkg::*; #(
    parameter cyc_t NBITS    = 16,
    parameter cyc_t SLOT_CYC = 15_625,
    parameter cyc_t PW_CYC   = 13,
    parameter cyc_t SLOT_W   = 5,
    parameter cyc_t POS_W    = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    output logic [SLOT_W-1:0] slot_o,
    output logic [POS_W-1:0]  pos_o,
    output logic              last_o
);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(SLOT_CYC - 1);
    localparam logic [POS_W-1:0]  PULSE_END = POS_W'(PW_CYC - 1);
    localparam logic [SLOT_W-1:0] CLOSE_SLOT = SLOT_W'(NBITS);

    logic [SLOT_W-1:0] slot_q;
    logic [POS_W-1:0]  pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            pos_q  <= '0;
        end else if (ctl.launch) begin
            slot_q <= '0;
            pos_q  <= '0;
        end else if (ctl.in_burst) begin
            if (pos_q == POS_LAST) begin
                pos_q  <= '0;
                slot_q <= slot_q + 1'b1;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign slot_o = slot_q;
    assign pos_o  = pos_q;
    assign last_o = (slot_q == CLOSE_SLOT) && (pos_q == PULSE_END);

endmodule

// File: rtl/flp_pulse_encoder.sv
module flp_pulse_encoder import flp_pkg::*; #(
    parameter cyc_t NBITS    = 16,
    parameter cyc_t PW_CYC   = 13,
    parameter cyc_t DOFS_CYC = 7_750,
    parameter cyc_t SLOT_W   = 5,
    parameter cyc_t POS_W    = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_ctl_t          ctl,
    input  logic [NBITS-1:0]  code_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic              pulse_o
);
    localparam logic [POS_W:0] CLK_END  = (POS_W + 1)'(PW_CYC);
    localparam logic [POS_W:0] DAT_BEG  = (POS_W + 1)'(DOFS_CYC);
    localparam logic [POS_W:0] DAT_END  = (POS_W + 1)'(DOFS_CYC + PW_CYC);
    localparam logic [SLOT_W-1:0] DATA_SLOTS = SLOT_W'(NBITS);

    logic [NBITS-1:0] word_q;
    logic [NBITS-1:0] shifted;
    logic [POS_W:0]   pos_x;
    logic             clk_win, dat_win;

    always_ff @(posedge clk) begin
        if (rst)             word_q <= '0;
        else if (ctl.launch) word_q <= code_i;
    end

    always_comb begin
        shifted = word_q >> slot_i;
        pos_x   = {1'b0, pos_i};
        clk_win = (pos_x < CLK_END);
        dat_win = (pos_x >= DAT_BEG) && (pos_x < DAT_END)
                  && (slot_i < DATA_SLOTS) && shifted[0];
        pulse_o = ctl.in_burst && (clk_win || dat_win);
    end

endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen import flp_pkg::*; #(
    parameter longint unsigned CLK_HZ      = 125_000_000,
    parameter cyc_t            NBITS       = 16,
    parameter longint unsigned PULSE_NS    = 100,
    parameter longint unsigned SLOT_NS     = 125_000,
    parameter longint unsigned DATA_OFS_NS = 62_000,
    parameter longint unsigned PERIOD_NS   = 16_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [NBITS-1:0] code_word,
    output logic             link_pulse,
    output logic             burst_active,
    output logic             burst_done
);
    localparam cyc_t PW_CYC     = ns_to_cyc(CLK_HZ, PULSE_NS);
    localparam cyc_t SLOT_CYC   = ns_to_cyc(CLK_HZ, SLOT_NS);
    localparam cyc_t DOFS_CYC   = ns_to_cyc(CLK_HZ, DATA_OFS_NS);
    localparam cyc_t PERIOD_CYC = ns_to_cyc(CLK_HZ, PERIOD_NS);
    localparam cyc_t BURST_CYC  = NBITS * SLOT_CYC + PW_CYC;
    localparam cyc_t SLOT_W     = cnt_width(NBITS + 1);
    localparam cyc_t POS_W      = cnt_width(SLOT_CYC);

    seq_ctl_t          ctl;
    logic [SLOT_W-1:0] slot;
    logic [POS_W-1:0]  pos;
    logic              last;

    flp_sequencer #(
        .PERIOD_CYC(PERIOD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .burst_last(last),
        .ctl       (ctl),
        .done_o    (burst_done)
    );

    flp_slot_counter #(
        .NBITS   (NBITS),
        .SLOT_CYC(SLOT_CYC),
        .PW_CYC  (PW_CYC),
        .SLOT_W  (SLOT_W),
        .POS_W   (POS_W)
    ) u_slots (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .slot_o(slot),
        .pos_o (pos),
        .last_o(last)
    );

    flp_pulse_encoder #(
        .NBITS   (NBITS),
        .PW_CYC  (PW_CYC),
        .DOFS_CYC(DOFS_CYC),
        .SLOT_W  (SLOT_W),
        .POS_W   (POS_W)
    ) u_enc (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .code_i (code_word),
        .slot_i (slot),
        .pos_i  (pos),
        .pulse_o(link_pulse)
    );

    assign burst_active = ctl.in_burst;

endmodule

// File: rtl/flp_burst_gen_chk.sv
module flp_burst_gen_chk import flp_pkg::*; #(
    parameter cyc_t PERIOD_CYC = 2_000_000,
    parameter cyc_t BURST_CYC  = 250_013
) (
    input logic clk,
    input logic rst,
    input logic link_pulse,
    input logic burst_active,
    input logic burst_done
);
    localparam cyc_t CW = cnt_width(PERIOD_CYC + 2);

    logic          act_prev;
    logic          seen_q;
    logic [CW-1:0] since_q;
    logic [CW-1:0] len_q;
    logic          act_rise;

    assign act_rise = burst_active && !act_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prev <= 1'b0;
            seen_q   <= 1'b0;
            since_q  <= '0;
            len_q    <= '0;
        end else begin
            act_prev <= burst_active;
            if (act_rise) begin
                seen_q  <= 1'b1;
                since_q <= CW'(1);
                len_q   <= CW'(1);
            end else begin
                if (since_q != CW'(PERIOD_CYC)) since_q <= since_q + 1'b1;
                if (burst_active) len_q <= len_q + 1'b1;
            end
        end
    end

    // R1: outputs cleared after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!link_pulse && !burst_active && !burst_done));

    // R2: pulses appear only inside a burst
    a_r2_pulse_in_burst: assert property (@(posedge clk) disable iff (rst)
        link_pulse |-> burst_active);

    // R2: a burst opens with a clock pulse
    a_r2_opens_with_pulse: assert property (@(posedge clk) disable iff (rst)
        act_rise |-> link_pulse);

    // R6: burst starts never closer than the period
    a_r6_min_spacing: assert property (@(posedge clk) disable iff (rst)
        (act_rise && seen_q) |-> (since_q >= CW'(PERIOD_CYC)));

    // R8: burst length
    a_r8_burst_length: assert property (@(posedge clk) disable iff (rst)
        $fell(burst_active) |-> (len_q == CW'(BURST_CYC)));

    // R8: done strobe follows the end of the burst
    a_r8_done_on_end: assert property (@(posedge clk) disable iff (rst)
        $fell(burst_active) |-> burst_done);

    // R8: done is a single-cycle strobe
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);

endmodule

bind flp_burst_gen flp_burst_gen_chk #(
    .PERIOD_CYC(PERIOD_CYC),
    .BURST_CYC (BURST_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_pulse  (link_pulse),
    .burst_active(burst_active),
    .burst_done  (burst_done)
);

// File: tb/tb_flp_burst_gen.sv
module tb_flp_burst_gen;
    // Small configuration: 125 MHz, 20 ns pulse -> 3 cycles (rounded up, R9),
    // 160 ns slot -> 20, 80 ns data offset -> 10, 4000 ns period -> 500
    localparam int NB     = 16;
    localparam int SLOT   = 20;
    localparam int PW     = 3;
    localparam int DOFS   = 10;
    localparam int PER    = 500;
    localparam int LAST_T = NB * SLOT + PW - 1;
    localparam int NW     = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [NB-1:0] code_word = '0;
    logic          link_pulse, burst_active, burst_done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flp_burst_gen #(
        .CLK_HZ     (125_000_000),
        .NBITS      (NB),
        .PULSE_NS   (20),
        .SLOT_NS    (160),
        .DATA_OFS_NS(80),
        .PERIOD_NS  (4000)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .code_word   (code_word),
        .link_pulse  (link_pulse),
        .burst_active(burst_active),
        .burst_done  (burst_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    function automatic logic [NB-1:0] word_of(input int i);
        if (i < NB) return NB'(1) << i;
        case (i)
            16: return 16'h0000;
            17: return 16'hFFFF;
            18: return 16'hAAAA;
            19: return 16'h5555;
            20: return 16'h8001;
            default: return 16'hC3A5;
        endcase
    endfunction

    function automatic bit exp_pulse(input logic [NB-1:0] w, input int t);
        int s, p;
        s = t / SLOT;
        p = t % SLOT;
        if (t > LAST_T) return 1'b0;
        if (p < PW) return 1'b1;
        if (s >= NB) return 1'b0;
        return w[s] && (p >= DOFS) && (p < DOFS + PW);
    endfunction

    // Called at the negedge where t = 0 of a burst is visible; returns at t = PER-1
    task automatic observe_burst(input logic [NB-1:0] w, input logic [NB-1:0] next_w,
                                 input bit drop_en, input string req);
        int pm = 0, late = 0, am = 0, dm = 0, hi = 0, ft = -1, fg = 0, fe = 0, ones = 0;
        bit ep, ea, ed;
        for (int t = 0; t < PER; t++) begin
            if (t > 0) @(negedge clk);
            if (t == 100) code_word = next_w;     // R5: mid-burst change
            if (t == 150 && drop_en) enable = 1'b0; // R7: drop mid-burst
            ep = exp_pulse(w, t);
            ea = (t <= LAST_T);
            ed = (t == LAST_T + 1);
            if (link_pulse !== ep) begin
                if (pm == 0) begin ft = t; fg = int'(link_pulse); fe = int'(ep); end
                pm++;
                if (t >= 100) late++;
            end
            if (burst_active !== ea) am++;
            if (burst_done !== ed) dm++;
            if (link_pulse === 1'b1) hi++;
        end
        for (int b = 0; b < NB; b++) ones += int'(w[b]);
        // R2, R3, R4: cycle-exact pattern (req names R4 for walking-one words)
        check(pm == 0, req, $sformatf("pulse pattern word=%h first_t=%0d", w, ft), fg, fe);
        // R5: no deviation after the input changed mid-burst
        check(late == 0, "R5", $sformatf("mismatch after code change word=%h", w), late, 0);
        // R9: total pulse-high cycles uses the rounded-up width
        check(hi == (NB + 1 + ones) * PW, "R9", $sformatf("pulse cycles word=%h", w),
              hi, (NB + 1 + ones) * PW);
        // R8: active window and done strobe
        check(am == 0, "R8", "burst_active window mismatches", am, 0);
        check(dm == 0, "R8", "burst_done strobe mismatches", dm, 0);
    endtask

    task automatic watch_quiet(input int n, input string req);
        int act = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (burst_active || link_pulse || burst_done) act++;
        end
        check(act == 0, req, "activity while disabled", act, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(link_pulse == 1'b0,   "R1", "link_pulse in reset",   int'(link_pulse), 0);
        check(burst_active == 1'b0, "R1", "burst_active in reset", int'(burst_active), 0);
        check(burst_done == 1'b0,   "R1", "burst_done in reset",   int'(burst_done), 0);
        rst = 1'b0;
        watch_quiet(40, "R7");

        code_word = word_of(0);
        enable = 1'b1;
        @(negedge clk);
        // R10: start from idle on the next edge
        check(burst_active && link_pulse, "R10", "start from idle",
              int'(burst_active && link_pulse), 1);

        for (int i = 0; i < NW; i++) begin
            observe_burst(word_of(i), word_of(i + 1), 1'b0, (i < NB) ? "R4" : "R3");
            @(negedge clk);
            // R6: next burst exactly one period later
            check(burst_active == 1'b1, "R6", $sformatf("restart after period, burst %0d", i),
                  int'(burst_active), 1);
        end

        // R7: drop enable inside the burst; it completes, then nothing follows
        observe_burst(word_of(NW), 16'hFFFF, 1'b1, "R7");
        watch_quiet(1200, "R7");

        code_word = 16'h1234;
        enable = 1'b1;
        @(negedge clk);
        check(burst_active && link_pulse, "R10", "restart from idle",
              int'(burst_active && link_pulse), 1);
        observe_burst(16'h1234, 16'h0000, 1'b1, "R3");
        watch_quiet(600, "R7");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) got=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule